// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor with Halt

This block is a 32-bit processor that completes every instruction in one clock. It holds the program counter, a 32-entry register file, an ALU, a main decoder and an ALU-operation decoder. It also holds two internal word arrays: a read-only instruction store and a separate read/write data store. The instruction set is small. It covers word load and store, branch-if-equal and five register-to-register operations (AND, OR, ADD, SUB and signed set-less-than). A halt instruction stops the machine and raises an output flag.

Both stores are filled through a load port while reset is held low. The program then runs from address zero until it reaches a halt. After that, the contents of the data store are read back one word at a time through the dump port. A dump request selects the word on the dump address and shows it on the dump data output.

Top module: `sc_cpu`

## Requirements
- R1: Opcode 000000 is the register-register format, with fields rs [25:21], rt [20:16], rd [15:11] and function [5:0]. Function 100000 writes rs+rt to rd, 100010 writes rs-rt, 100100 writes rs AND rt, and 100101 writes rs OR rt.
- R2: Function 101010 writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise (this includes equal operands).
- R3: Load (opcode 100011) and store (opcode 101011) use the address rs plus the sign-extended 16-bit immediate in bits [15:0]. The word index is address bits [31:2], taken modulo the data store depth. A load writes rt and a store writes the value of rt.
- R4: Branch (opcode 000100) sets the next PC to PC+4+(sign-extended immediate shifted left by 2) when rs equals rt, and to PC+4 otherwise. Backward targets work.
- R5: Register 0 always reads as zero. A write to it, whether from an ALU result or a load, has no effect.
- R6: Opcode 111111 is a halt. The halt output rises at the clock edge that executes it, so with N instructions before the halt it is low after N edges and high after N+1 edges. A halt at address 0 raises the output at the first edge.
- R7: Once halted, the PC stops, no register or data-store write occurs and the halt output stays high until reset.
- R8: Reset is synchronous and active low. It sets the PC to 0, clears all registers and clears the halt output, and it keeps the contents of both stores. Load-port writes take effect only while reset is low.
- R9: While the dump request is high, the dump data output shows the data-store word selected by the dump address, in the same cycle. While the request is low, the output is zero.
- R10: Any other opcode, and any register-format function code not listed in R1 or R2, writes nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Load-port write strobe, used only during reset |
| load_to_data | input | 1 | 1 selects the data store, 0 selects the instruction store |
| load_addr | input | 6 | Word index for the load port |
| load_data | input | 32 | Word written by the load port |
| dump_req | input | 1 | Dump request |
| dump_addr | input | 6 | Data-store word index to show |
| dump_data | output | 32 | Selected data word, or zero when no request is made |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The assertions assume three things. The load port is driven only while reset is low. Every program ends in a halt. The dump port is read only while the machine is halted, so a readout never races a store. The stimulus keeps to these rules. Every program is loaded in full during reset, a halt is placed after every generated sequence and the unused instruction words are filled with halts. Random programs address memory only through register 0 with aligned offsets that stay inside the data store. The directed programs are written so that every base-plus-offset and branch target lands on a valid word.

// File: rtl/cpu_pkg.sv
// Package: shared widths, instruction encodings and control types for the
// single-cycle processor. Assumes a 32-bit word and a 32-entry register file.
package cpu_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RAW  = $clog2(NREG);

    // Major opcodes (bits [31:26])
    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_STOP  = 6'b111111;

    // Register-format function codes (bits [5:0])
    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT,
        ALU_NONE
    } alu_op_e;

    // Class of ALU work chosen by the main decoder
    typedef enum logic [1:0] {
        CLS_ADD,
        CLS_SUB,
        CLS_FUNCT
    } alu_cls_e;

    typedef struct packed {
        logic    reg_write;
        logic    dst_is_rd;
        logic    src_is_imm;
        logic    load;
        logic    store;
        logic    branch;
        logic    halt;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/cpu_decode.sv
// Module: combinational control decoder.
// The main decoder maps the opcode to datapath controls and an ALU class.
// The ALU-operation decoder then resolves the class, using the function field
// for register-format work. No state is held. An unknown opcode or function
// code yields controls that write nothing.
module cpu_decode
    import cpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);

    ctrl_t    main_ctl;
    alu_cls_e cls;
    alu_op_e  op_sel;

    // Main decoder: opcode to datapath controls
    always_comb begin
        main_ctl = '0;
        main_ctl.alu_op = ALU_NONE;
        cls = CLS_ADD;
        case (opcode)
            OPC_REG: begin
                main_ctl.reg_write = 1'b1;
                main_ctl.dst_is_rd = 1'b1;
                cls = CLS_FUNCT;
            end
            OPC_LOAD: begin
                main_ctl.reg_write  = 1'b1;
                main_ctl.src_is_imm = 1'b1;
                main_ctl.load       = 1'b1;
                cls = CLS_ADD;
            end
            OPC_STORE: begin
                main_ctl.src_is_imm = 1'b1;
                main_ctl.store      = 1'b1;
                cls = CLS_ADD;
            end
            OPC_BEQ: begin
                main_ctl.branch = 1'b1;
                cls = CLS_SUB;
            end
            OPC_STOP: begin
                main_ctl.halt = 1'b1;
            end
            default: begin
                main_ctl = '0;
                main_ctl.alu_op = ALU_NONE;
            end
        endcase
    end

    // ALU-operation decoder: class plus function field to ALU operation
    always_comb begin
        case (cls)
            CLS_ADD: op_sel = ALU_ADD;
            CLS_SUB: op_sel = ALU_SUB;
            default: begin
                case (funct)
                    FN_ADD:  op_sel = ALU_ADD;
                    FN_SUB:  op_sel = ALU_SUB;
                    FN_AND:  op_sel = ALU_AND;
                    FN_OR:   op_sel = ALU_OR;
                    FN_SLT:  op_sel = ALU_SLT;
                    default: op_sel = ALU_NONE;
                endcase
            end
        endcase
    end

    // Merge: drop the register write when the function code is unsupported
    always_comb begin
        ctl = main_ctl;
        ctl.alu_op = op_sel;
        ctl.reg_write = main_ctl.reg_write && (op_sel != ALU_NONE);
    end

endmodule

// File: rtl/cpu_regfile.sv
// Module: register file with two read ports and one write port.
// Register 0 is hard-wired to zero: reads of it return zero and writes to it
// are dropped. The synchronous active-low reset clears every entry.
module cpu_regfile
    import cpu_pkg::*;
#(
    parameter int N_REGS = NREG,
    parameter int WIDTH  = XLEN,
    localparam int AW    = $clog2(N_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_a_idx,
    input  logic [AW-1:0]    rd_b_idx,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_val,
    output logic [WIDTH-1:0] rd_a_val,
    output logic [WIDTH-1:0] rd_b_val
);

    logic [WIDTH-1:0] regs_q [N_REGS];

    // Storage update: clear on reset, otherwise write any non-zero index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REGS; i++) regs_q[i] <= '0;
        end else if (wr_en && (wr_idx != '0)) begin
            regs_q[wr_idx] <= wr_val;
        end
    end

    // Read ports: index 0 forced to zero
    always_comb begin
        rd_a_val = (rd_a_idx == '0) ? '0 : regs_q[rd_a_idx];
        rd_b_val = (rd_b_idx == '0) ? '0 : regs_q[rd_b_idx];
    end

    // Entry 0 never takes a value, whatever the write port is asked to do
    assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[0] == '0);

    // A write aimed at entry 0 leaves the read value of every port zero for it
    assert_zero_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0) |=> (regs_q[0] == '0));

endmodule

// File: rtl/cpu_alu.sv
// Module: combinational ALU.
// Supports add, subtract, AND, OR and signed set-less-than. The zero flag
// reports an all-zero result and is used by the branch-if-equal compare.
module cpu_alu
    import cpu_pkg::*;
#(
    parameter int WIDTH = XLEN
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] res,
    output logic             is_zero
);

    // Operation select
    always_comb begin
        case (op)
            ALU_ADD: res = opa + opb;
            ALU_SUB: res = opa - opb;
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            ALU_SLT: res = {{(WIDTH-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: res = '0;
        endcase
    end

    // Zero flag
    assign is_zero = (res == '0);

endmodule

// File: rtl/sc_cpu.sv
// Module: single-cycle processor top.
// Fetches from an internal instruction store at the PC, decodes, executes and
// writes back in one clock. Both stores are filled through the load port while
// rst_n is low. Their contents survive reset. A halt instruction freezes the
// PC and all writes until the next reset. The dump port reads the data store
// combinationally.
module sc_cpu
    import cpu_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic            load_to_data,
    input  logic [LAW-1:0]  load_addr,
    input  logic [XLEN-1:0] load_data,
    input  logic            dump_req,
    input  logic [DAW-1:0]  dump_addr,
    output logic [XLEN-1:0] dump_data,
    output logic            halted
);

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q;
    logic            halted_q;
    logic [XLEN-1:0] instr;
    ctrl_t           ctl;

    logic [RAW-1:0]  f_rs, f_rt, f_rd;
    logic [XLEN-1:0] imm_sext;
    logic [XLEN-1:0] rs_val, rt_val;
    logic [XLEN-1:0] alu_b, alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] wb_val;
    logic [RAW-1:0]  wb_idx;
    logic            run;
    logic            reg_we, dmem_we;
    logic [DAW-1:0]  dmem_idx;
    logic [XLEN-1:0] pc_plus4, pc_branch, pc_next;

    // Instruction fetch and field split
    assign instr    = imem[pc_q[IAW+1:2]];
    assign f_rs     = instr[25:21];
    assign f_rt     = instr[20:16];
    assign f_rd     = instr[15:11];
    assign imm_sext = {{(XLEN-16){instr[15]}}, instr[15:0]};

    cpu_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctl    (ctl)
    );

    // Write enables gated by the halt state and by a halt in execution
    assign run     = !halted_q && !ctl.halt;
    assign reg_we  = ctl.reg_write && run;
    assign dmem_we = ctl.store && run;

    cpu_regfile #(.N_REGS(NREG), .WIDTH(XLEN)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (f_rs),
        .rd_b_idx (f_rt),
        .wr_en    (reg_we),
        .wr_idx   (wb_idx),
        .wr_val   (wb_val),
        .rd_a_val (rs_val),
        .rd_b_val (rt_val)
    );

    assign alu_b = ctl.src_is_imm ? imm_sext : rt_val;

    cpu_alu #(.WIDTH(XLEN)) u_alu (
        .opa     (rs_val),
        .opb     (alu_b),
        .op      (ctl.alu_op),
        .res     (alu_y),
        .is_zero (alu_zero)
    );

    // Data store addressing and write-back select
    assign dmem_idx = alu_y[DAW+1:2];
    assign wb_val   = ctl.load ? dmem[dmem_idx] : alu_y;
    assign wb_idx   = ctl.dst_is_rd ? f_rd : f_rt;

    // Next-PC selection
    assign pc_plus4  = pc_q + XLEN'(4);
    assign pc_branch = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
    assign pc_next   = (ctl.branch && alu_zero) ? pc_branch : pc_plus4;

    // PC and halt state: clear on reset, freeze once halted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= '0;
            halted_q <= 1'b0;
        end else if (!halted_q) begin
            if (ctl.halt) halted_q <= 1'b1;
            else          pc_q     <= pc_next;
        end
    end

    // Instruction store: written only by the load port during reset
    always_ff @(posedge clk) begin
        if (!rst_n && load_en && !load_to_data) imem[load_addr[IAW-1:0]] <= load_data;
    end

    // Data store: load-port writes in reset, store instructions when running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (load_en && load_to_data) dmem[load_addr[DAW-1:0]] <= load_data;
        end else if (dmem_we) begin
            dmem[dmem_idx] <= rt_val;
        end
    end

    // Dump readout
    assign dump_data = dump_req ? dmem[dump_addr] : '0;
    assign halted    = halted_q;

    logic unused_bits;
    assign unused_bits = ^{pc_q[XLEN-1:IAW+2], pc_q[1:0], alu_y[XLEN-1:DAW+2],
                           alu_y[1:0], load_addr};

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |=> halted_q);

    assert_pc_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |=> $stable(pc_q));

    assert_halt_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted_q) |-> ($past(instr[31:26]) == OPC_STOP));

    assert_pc_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[1:0] == 2'b00);

    assert_branch_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_q && ctl.branch && (rs_val == rt_val))
        |=> (pc_q == $past(pc_q) + XLEN'(4) + {$past(imm_sext[XLEN-3:0]), 2'b00}));

    assert_branch_not_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_q && ctl.branch && (rs_val != rt_val))
        |=> (pc_q == $past(pc_q) + XLEN'(4)));

    assert_ctl_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl.reg_write, ctl.store, ctl.branch, ctl.halt}));

endmodule

// File: tb/sc_cpu_test.sv
`timescale 1ns/100ps
// Bench: loads programs through the load port. A bench-side instruction-level
// model predicts the halt cycle and the final data store. The bench then
// compares them at the ports.
module sc_cpu_test;

    localparam int NW = 64;
    localparam logic [31:0] HALT_W = 32'hFC00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic        load_to_data = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic        dump_req = 1'b0;
    logic [5:0]  dump_addr = '0;
    logic [31:0] dump_data;
    logic        halted;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] pim [NW];
    logic [31:0] pdm [NW];
    logic [31:0] sdm [NW];
    logic [31:0] srf [32];

    always #2.5 clk = ~clk;

    sc_cpu uut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_to_data(load_to_data),
        .load_addr(load_addr), .load_data(load_data), .dump_req(dump_req),
        .dump_addr(dump_addr), .dump_data(dump_data), .halted(halted)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    // Instruction-level model of the requirements; returns instructions before halt
    task automatic model_run(output int n);
        logic [31:0] pc, ins, a, b, addr, sx;
        n = 0;
        pc = 0;
        for (int i = 0; i < 32; i++) srf[i] = '0;
        for (int i = 0; i < NW; i++) sdm[i] = pdm[i];
        while (n < 5000) begin
            ins = pim[pc[7:2]];
            if (ins[31:26] == 6'h3f) break;
            a = srf[ins[25:21]];
            b = srf[ins[20:16]];
            sx = {{16{ins[15]}}, ins[15:0]};
            addr = a + sx;
            case (ins[31:26])
                6'h00: begin
                    logic [31:0] r;
                    bit wr;
                    wr = 1;
                    case (ins[5:0])
                        6'h20: r = a + b;
                        6'h22: r = a - b;
                        6'h24: r = a & b;
                        6'h25: r = a | b;
                        6'h2a: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                        default: begin r = '0; wr = 0; end
                    endcase
                    if (wr && ins[15:11] != 0) srf[ins[15:11]] = r;
                end
                6'h23: if (ins[20:16] != 0) srf[ins[20:16]] = sdm[addr[7:2]];
                6'h2b: sdm[addr[7:2]] = b;
                default: ;
            endcase
            if (ins[31:26] == 6'h04 && a == b) pc = pc + 4 + {sx[29:0], 2'b00};
            else pc = pc + 4;
            n++;
        end
    endtask

    // Full run: reset and load, predict, execute, then compare halt timing and store
    task automatic run_prog(input string tag);
        int n;
        logic [31:0] v;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < NW; i++) begin
            load_en = 1'b1; load_to_data = 1'b0; load_addr = 6'(i); load_data = pim[i];
            @(negedge clk);
        end
        for (int i = 0; i < NW; i++) begin
            load_en = 1'b1; load_to_data = 1'b1; load_addr = 6'(i); load_data = pdm[i];
            @(negedge clk);
        end
        load_en = 1'b0;
        check(halted == 1'b0, "R8 halt cleared by reset", 32'(halted), 32'd0);
        model_run(n);
        rst_n = 1'b1;
        repeat (n) @(negedge clk);
        check(halted == 1'b0, "R6 low before halt edge", 32'(halted), 32'd0);
        @(negedge clk);
        check(halted == 1'b1, "R6 high after halt edge", 32'(halted), 32'd1);
        repeat (8) @(negedge clk);
        check(halted == 1'b1, "R7 halt held", 32'(halted), 32'd1);
        for (int i = 0; i < NW; i++) begin
            dump_req = 1'b1; dump_addr = 6'(i);
            #0.5;
            v = dump_data;
            check(v === sdm[i], tag, v, sdm[i]);
        end
        dump_req = 1'b0;
        #0.5;
        check(dump_data == '0, "R9 idle dump zero", dump_data, 32'd0);
    endtask

    task automatic fill_default();
        for (int i = 0; i < NW; i++) begin
            pim[i] = HALT_W;
            pdm[i] = 32'(i) * 32'h0101_0101;
        end
    endtask

    function automatic logic [31:0] dump_word(input int idx);
        return sdm[idx];
    endfunction

    task automatic read_dump(input int idx, output logic [31:0] v);
        dump_req = 1'b1; dump_addr = 6'(idx);
        #0.5;
        v = dump_data;
        dump_req = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        logic [5:0] fns [5];
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2a;
        void'($urandom(32'd20240417));
        repeat (3) @(negedge clk);
        check(halted == 1'b0, "R8 reset state", 32'(halted), 32'd0);

        // R6: halt at address 0
        fill_default();
        run_prog("R6 store untouched");

        // R1/R2: random register-format programs
        for (int t = 0; t < 30; t++) begin
            fill_default();
            for (int i = 0; i < 8; i++) begin
                if ((i > 0) && ($urandom % 4 == 0)) pdm[i] = pdm[i-1];
                else if ($urandom % 3 == 0) pdm[i] = 32'h8000_0000 | $urandom;
                else pdm[i] = $urandom;
                pim[i] = enc_i(6'h23, 5'd0, 5'(i + 1), 16'(i * 4));
            end
            for (int i = 8; i < 20; i++)
                pim[i] = enc_r(5'($urandom % 9), 5'($urandom % 9), 5'($urandom % 10),
                               fns[$urandom % 5]);
            for (int i = 0; i < 10; i++)
                pim[20 + i] = enc_i(6'h2b, 5'd0, 5'(i), 16'(160 + 4 * i));
            run_prog("R1 random ops");
        end

        // R2/R5/R10/R7: directed program
        fill_default();
        pdm[0] = 32'h8000_0000; pdm[1] = 32'd1; pdm[2] = 32'd5; pdm[3] = 32'd5;
        pim[0]  = enc_i(6'h23, 0, 1, 16'd0);
        pim[1]  = enc_i(6'h23, 0, 2, 16'd4);
        pim[2]  = enc_r(1, 2, 3, 6'h2a);
        pim[3]  = enc_r(2, 1, 4, 6'h2a);
        pim[4]  = enc_i(6'h23, 0, 5, 16'd8);
        pim[5]  = enc_i(6'h23, 0, 6, 16'd12);
        pim[6]  = enc_r(5, 6, 7, 6'h2a);
        pim[7]  = enc_r(1, 2, 0, 6'h20);
        pim[8]  = enc_i(6'h23, 0, 0, 16'd8);
        pim[9]  = enc_i(6'h08, 0, 8, 16'd7);
        pim[10] = enc_r(1, 2, 9, 6'h21);
        pim[11] = enc_i(6'h2b, 0, 3, 16'd80);
        pim[12] = enc_i(6'h2b, 0, 4, 16'd84);
        pim[13] = enc_i(6'h2b, 0, 7, 16'd88);
        pim[14] = enc_i(6'h2b, 0, 0, 16'd92);
        pim[15] = enc_i(6'h2b, 0, 8, 16'd96);
        pim[16] = enc_i(6'h2b, 0, 9, 16'd100);
        pim[17] = HALT_W;
        pim[18] = enc_i(6'h2b, 0, 1, 16'd104);
        run_prog("R5 directed store");
        read_dump(20, v); check(v == 32'd1, "R2 negative below positive", v, 32'd1);
        read_dump(21, v); check(v == 32'd0, "R2 positive not below negative", v, 32'd0);
        read_dump(22, v); check(v == 32'd0, "R2 equal operands", v, 32'd0);
        read_dump(23, v); check(v == 32'd0, "R5 register 0 after writes", v, 32'd0);
        read_dump(24, v); check(v == 32'd0, "R10 unknown opcode no write", v, 32'd0);
        read_dump(25, v); check(v == 32'd0, "R10 unknown function no write", v, 32'd0);
        read_dump(26, v);
        check(v == 32'd26 * 32'h0101_0101, "R7 no store after halt", v, 32'd26 * 32'h0101_0101);

        // R4/R3: loop with backward branch, not-taken branch, negative offset
        fill_default();
        pdm[0] = 32'd3; pdm[1] = 32'd1; pdm[2] = 32'd24; pdm[4] = 32'h1234_5678;
        pim[0]  = enc_i(6'h23, 0, 4, 16'd0);
        pim[1]  = enc_i(6'h23, 0, 5, 16'd4);
        pim[2]  = enc_r(4, 5, 4, 6'h22);
        pim[3]  = enc_r(6, 5, 6, 6'h20);
        pim[4]  = enc_i(6'h04, 4, 0, 16'd1);
        pim[5]  = enc_i(6'h04, 0, 0, 16'hFFFC);
        pim[6]  = enc_i(6'h2b, 0, 6, 16'd40);
        pim[7]  = enc_i(6'h04, 1, 5, 16'd1);
        pim[8]  = enc_i(6'h2b, 0, 5, 16'd44);
        pim[9]  = enc_i(6'h23, 0, 10, 16'd8);
        pim[10] = enc_i(6'h23, 10, 11, 16'hFFF8);
        pim[11] = enc_i(6'h2b, 10, 11, 16'hFFFC);
        pim[12] = HALT_W;
        run_prog("R4 branch program");
        read_dump(10, v); check(v == 32'd3, "R4 loop count", v, 32'd3);
        read_dump(11, v); check(v == 32'd1, "R4 not-taken falls through", v, 32'd1);
        read_dump(5, v);
        check(v == 32'h1234_5678, "R3 negative offset load/store", v, 32'h1234_5678);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule